// File: doc/BRIEF.md
# Sequencer Debug Freeze Controller

This block puts a queued conversion sequencer into a debug halt and brings it back out. Freezing happens when a software enable bit in the control register is set and an external halt-request input is high. The controller waits for the current conversion to finish, so a freeze never splits a command word. While frozen, it keeps two things in reset: the conversion clock prescaler and the periodic interval timer. Trigger edges that arrive during the freeze are discarded. Triggers that were already pending stay pending.

The index of the next command word is kept across the freeze. When the halt request is removed, the controller looks at three things: the saved index, the current queue mode and the pending triggers. If software wrote a different queue mode while the block was frozen, execution restarts from command 0. Otherwise it continues from the saved index. The small register port can be read and written in every state.

Top module: `seq_freeze_ctrl`

## Requirements
- R1: A freeze starts only when control bit 0 (freeze enable) is 1 and `frz_in` is high. With the enable at 0, `frozen` is low one cycle later and commands keep starting.
- R2: A freeze is accepted only while no conversion is running (`conv_busy` low). No command starts while a freeze is being requested or is in force.
- R3: `frozen` goes high in the cycle after a freeze is accepted. It goes low in the cycle after the request is removed.
- R4: While `frozen` is high, `qclk_tick` stays low. After exit, the prescaler restarts from zero, so the first tick comes PRESC_DIV cycles after `frozen` falls.
- R5: While frozen, the interval timer is held at zero. After exit, its first expiry comes a full PIT_PERIOD prescaler ticks later.
- R6: A rising edge on `ext_trig` while frozen never becomes pending. A level that rose during the freeze and is still held after exit does not count as an edge.
- R7: `trig_pend` (bit 0 = external trigger, bit 1 = timer) has the same value when the freeze is left as it had when the freeze was entered.
- R8: If the queue mode did not change while frozen, the first command after exit uses the index that was saved at entry.
- R9: If the queue mode was rewritten while frozen, the first command after exit has index 0.
- R10: Register writes and reads work in every state. Address 0 is the control register: bit 0 is the freeze enable, bits 2:1 are the queue mode, and the upper bits are stored. Address 1 reads the next index. Address 2 reads {frozen, pend[1:0]} in bits 2:0. Any other address reads as 0.
- R11: Queue modes are 0 = off, 1 = external trigger, 2 = interval timer, 3 = continuous. A command starts when the selected source is pending, or always in mode 3, and the start consumes that pending flag. The index wraps from QUEUE_LEN-1 to 0.
- R12: A started conversion keeps `conv_busy` high until CONV_TICKS prescaler ticks have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frz_in | input | 1 | Debug halt request |
| ext_trig | input | 1 | External trigger level, rising edge detected |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from address |
| frozen | output | 1 | Freeze in force |
| qclk_tick | output | 1 | Conversion clock prescaler tick |
| pit_tick | output | 1 | Interval timer expiry |
| cmd_start | output | 1 | Command word starts this cycle |
| cmd_idx | output | PTR_W | Index of the next or starting command word |
| conv_busy | output | 1 | Conversion in progress |
| trig_pend | output | 2 | Pending triggers: bit 0 external, bit 1 timer |

## Verification
The hardest case to reach is a freeze request that arrives during a conversion while a trigger is already pending. The stimulus fires a trigger, fires a second one while the first conversion is still running, and then raises the halt request. Entry is then delayed to the conversion boundary, and the pending flag has to survive the freeze together with a discarded edge and register traffic. Separate phases rewrite the queue mode while frozen, drop the freeze in the middle of an interval-timer period, hold a trigger level high across exit, and clear the enable bit to leave a freeze.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    QM_OFF  = 2'd0,
    QM_EXT  = 2'd1,
    QM_PIT  = 2'd2,
    QM_CONT = 2'd3
  } qmode_e;

  typedef enum logic {
    FZ_RUN  = 1'b0,
    FZ_HELD = 1'b1
  } fz_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PTR  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int NUM_SRC = 2;

endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
  import sfc_pkg::*;
#(
  parameter  int DW    = 8,
  parameter  int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             frozen_i,
  input  logic [1:0]       pend_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [DW-1:0]    rdata_o,
  output logic             frz_en_o,
  output qmode_e           mode_o
);

  logic [DW-1:0] ctrl_q;
  logic          ctrl_en;

  assign ctrl_en = we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= wdata_i;
    end
  end

  assign frz_en_o = ctrl_q[0];
  assign mode_o   = qmode_e'(ctrl_q[2:1]);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_PTR:  rdata_o[PTR_W-1:0] = ptr_i;
      ADDR_STAT: rdata_o[2:0] = {frozen_i, pend_i};
      default:   rdata_o = '0;
    endcase
  end

  // R10
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en |=> (ctrl_q == $past(wdata_i)));

endmodule

// File: rtl/sfc_timebase.sv
module sfc_timebase #(
  parameter  int PRESC_DIV  = 4,
  parameter  int PIT_PERIOD = 5,
  localparam int PRE_W = $clog2(PRESC_DIV > 1 ? PRESC_DIV : 2),
  localparam int PIT_W = $clog2(PIT_PERIOD > 1 ? PIT_PERIOD : 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic qtick_o,
  output logic ptick_o
);

  generate
    if (PRESC_DIV == 1) begin : g_nodiv
      assign qtick_o = ~hold_i;
    end else begin : g_div
      logic [PRE_W-1:0] pre_q;
      logic [PRE_W-1:0] pre_n;
      logic             pre_wrap;

      assign pre_wrap = (pre_q == PRE_W'(PRESC_DIV - 1));

      always_comb begin
        if (hold_i) begin
          pre_n = '0;
        end else if (pre_wrap) begin
          pre_n = '0;
        end else begin
          pre_n = pre_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_n;
        end
      end

      assign qtick_o = ~hold_i & pre_wrap;
    end
  endgenerate

  logic [PIT_W-1:0] pit_q;
  logic [PIT_W-1:0] pit_n;
  logic             pit_wrap;
  logic             pit_en;

  assign pit_wrap = (pit_q == PIT_W'(PIT_PERIOD - 1));
  assign pit_en   = hold_i | qtick_o;

  always_comb begin
    if (hold_i || pit_wrap) begin
      pit_n = '0;
    end else begin
      pit_n = pit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pit_q <= '0;
    end else if (pit_en) begin
      pit_q <= pit_n;
    end
  end

  assign ptick_o = qtick_o & pit_wrap;

endmodule

// File: rtl/sfc_trig.sv
module sfc_trig
  import sfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_i,
  input  qmode_e     mode_i,
  input  logic       ext_trig_i,
  input  logic       ptick_i,
  input  logic       start_i,
  output logic [1:0] pend_o
);

  logic               trig_q;
  logic [NUM_SRC-1:0] evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
    end else begin
      trig_q <= ext_trig_i;
    end
  end

  assign evt[0] = ext_trig_i & ~trig_q;
  assign evt[1] = ptick_i;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      localparam qmode_e SRC_MODE = (g == 0) ? QM_EXT : QM_PIT;
      logic hit;
      logic take;
      logic pq;
      logic pn;

      assign hit  = evt[g] & ~hold_i & (mode_i == SRC_MODE);
      assign take = start_i & (mode_i == SRC_MODE);

      always_comb begin
        pn = (pq & ~take) | hit;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pq <= 1'b0;
        end else begin
          pq <= pn;
        end
      end

      assign pend_o[g] = pq;
    end
  endgenerate

  // R6
  frozen_edge_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !pend_o[0]) |=> !pend_o[0]);

endmodule

// File: rtl/sfc_core.sv
module sfc_core
  import sfc_pkg::*;
#(
  parameter  int QUEUE_LEN  = 6,
  parameter  int CONV_TICKS = 3,
  localparam int PTR_W = $clog2(QUEUE_LEN > 1 ? QUEUE_LEN : 2),
  localparam int CNV_W = $clog2(CONV_TICKS > 1 ? CONV_TICKS : 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frz_en_i,
  input  logic             frz_in_i,
  input  qmode_e           mode_i,
  input  logic [1:0]       pend_i,
  input  logic             qtick_i,
  output logic             frozen_o,
  output logic             start_o,
  output logic [PTR_W-1:0] idx_o,
  output logic             busy_o
);

  fz_state_e        st_q, st_n;
  qmode_e           snap_q;
  logic             busy_q, busy_n;
  logic [CNV_W-1:0] cnt_q, cnt_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic             req, go, entry, leave, start, ptr_en;

  assign req = frz_en_i & frz_in_i;

  always_comb begin
    unique case (mode_i)
      QM_EXT:  go = pend_i[0];
      QM_PIT:  go = pend_i[1];
      QM_CONT: go = 1'b1;
      default: go = 1'b0;
    endcase
  end

  assign entry = (st_q == FZ_RUN) & req & ~busy_q;
  assign leave = (st_q == FZ_HELD) & ~req;
  assign start = (st_q == FZ_RUN) & ~req & ~busy_q & go;

  always_comb begin
    st_n = st_q;
    if (entry) begin
      st_n = FZ_HELD;
    end else if (leave) begin
      st_n = FZ_RUN;
    end
  end

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (busy_q && qtick_i) begin
      if (cnt_q == CNV_W'(CONV_TICKS - 1)) begin
        busy_n = 1'b0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    ptr_n = ptr_q;
    if (start) begin
      ptr_n = (ptr_q == PTR_W'(QUEUE_LEN - 1)) ? '0 : ptr_q + 1'b1;
    end else if (leave && (mode_i != snap_q)) begin
      ptr_n = '0;
    end
  end

  assign ptr_en = start | leave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FZ_RUN;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_n;
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= QM_OFF;
    end else if (entry) begin
      snap_q <= mode_i;
    end
  end

  assign frozen_o = (st_q == FZ_HELD);
  assign start_o  = start;
  assign idx_o    = ptr_q;
  assign busy_o   = busy_q;

  // R1
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frz_en_i |=> !frozen_o);

  // R2
  held_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_o |-> (!busy_q && !start_o));

  // R4
  held_presc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_o |-> !qtick_i);

  // R11
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < QUEUE_LEN);

  // R12
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> busy_o);

endmodule

// File: rtl/seq_freeze_ctrl.sv
module seq_freeze_ctrl
  import sfc_pkg::*;
#(
  parameter  int DW         = 8,
  parameter  int QUEUE_LEN  = 6,
  parameter  int PRESC_DIV  = 4,
  parameter  int PIT_PERIOD = 5,
  parameter  int CONV_TICKS = 3,
  localparam int PTR_W = $clog2(QUEUE_LEN > 1 ? QUEUE_LEN : 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frz_in,
  input  logic             ext_trig,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             frozen,
  output logic             qclk_tick,
  output logic             pit_tick,
  output logic             cmd_start,
  output logic [PTR_W-1:0] cmd_idx,
  output logic             conv_busy,
  output logic [1:0]       trig_pend
);

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       frz_en;
  qmode_e     mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync[1];

  sfc_regs #(.DW(DW), .PTR_W(PTR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .we_i     (reg_we),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .frozen_i (frozen),
    .pend_i   (trig_pend),
    .ptr_i    (cmd_idx),
    .rdata_o  (reg_rdata),
    .frz_en_o (frz_en),
    .mode_o   (mode)
  );

  sfc_timebase #(.PRESC_DIV(PRESC_DIV), .PIT_PERIOD(PIT_PERIOD)) u_tb (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .hold_i  (frozen),
    .qtick_o (qclk_tick),
    .ptick_o (pit_tick)
  );

  sfc_trig u_trig (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .hold_i     (frozen),
    .mode_i     (mode),
    .ext_trig_i (ext_trig),
    .ptick_i    (pit_tick),
    .start_i    (cmd_start),
    .pend_o     (trig_pend)
  );

  sfc_core #(.QUEUE_LEN(QUEUE_LEN), .CONV_TICKS(CONV_TICKS)) u_core (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .frz_en_i (frz_en),
    .frz_in_i (frz_in),
    .mode_i   (mode),
    .pend_i   (trig_pend),
    .qtick_i  (qclk_tick),
    .frozen_o (frozen),
    .start_o  (cmd_start),
    .idx_o    (cmd_idx),
    .busy_o   (conv_busy)
  );

endmodule

// File: tb/seq_freeze_ctrl_tb.sv
`timescale 1ns/1ps
module seq_freeze_ctrl_tb;
  localparam int QL = 6, DIV = 4, PER = 5, CT = 3, DW = 8;
  localparam int PW = $clog2(QL);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, frz_in, ext_trig, reg_we;
  logic [1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic frozen, qclk_tick, pit_tick, cmd_start, conv_busy;
  logic [PW-1:0] cmd_idx;
  logic [1:0] trig_pend;

  seq_freeze_ctrl #(.DW(DW), .QUEUE_LEN(QL), .PRESC_DIV(DIV),
                    .PIT_PERIOD(PER), .CONV_TICKS(CT)) u_dut (
    .clk(clk), .rst_n(rst_n), .frz_in(frz_in), .ext_trig(ext_trig),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .frozen(frozen), .qclk_tick(qclk_tick),
    .pit_tick(pit_tick), .cmd_start(cmd_start), .cmd_idx(cmd_idx),
    .conv_busy(conv_busy), .trig_pend(trig_pend));

  int checks = 0, fails = 0, starts = 0, wd = 0;
  bit done = 0;
  // reference model state
  int m_ctrl = 0, m_st = 0, m_snap = 0, m_pre = 0, m_pit = 0;
  int m_busy = 0, m_conv = 0, m_ptr = 0, m_pe = 0, m_pt = 0, m_trq = 0;
  // directed monitors
  int prev_frozen = 0, prev_busy = 0, prev_en = 0;
  int armed = 0, exp_first = 0, ent_pend = 0;
  string first_tag = "R8";

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    int en, mode, req, qt, pt, go, st, ent, lv, edg, rd;
    int n_pre, n_pit, n_busy, n_conv, n_ptr, n_pe, n_pt;
    @(negedge clk); #1;
    en = m_ctrl & 1; mode = (m_ctrl >> 1) & 3;
    req = en & int'(frz_in);
    qt = (m_st == 0 && m_pre == DIV-1) ? 1 : 0;
    pt = (qt == 1 && m_pit == PER-1) ? 1 : 0;
    go = (mode == 1) ? m_pe : (mode == 2) ? m_pt : (mode == 3) ? 1 : 0;
    st = (m_st == 0 && req == 0 && m_busy == 0 && go == 1) ? 1 : 0;
    ent = (m_st == 0 && req == 1 && m_busy == 0) ? 1 : 0;
    lv = (m_st == 1 && req == 0) ? 1 : 0;
    edg = (ext_trig && m_trq == 0) ? 1 : 0;
    case (reg_addr)
      2'd0: rd = m_ctrl;
      2'd1: rd = m_ptr;
      2'd2: rd = m_st * 4 + m_pt * 2 + m_pe;
      default: rd = 0;
    endcase
    chk("R3", int'(frozen), m_st);
    chk("R4", int'(qclk_tick), qt);
    chk("R5", int'(pit_tick), pt);
    chk("R11", int'(cmd_start), st);
    chk("R11", int'(cmd_idx), m_ptr);
    chk("R12", int'(conv_busy), m_busy);
    chk("R6", int'(trig_pend), m_pt * 2 + m_pe);
    chk("R10", int'(reg_rdata), rd);
    // R2: entry only at a conversion boundary
    if (frozen && prev_frozen == 0) chk("R2", prev_busy, 0);
    // R1: enable cleared means not frozen one cycle later
    if (prev_en == 0) chk("R1", int'(frozen), 0);
    if (frozen) chk("R4", int'(qclk_tick), 0);
    if (cmd_start) starts++;
    if (cmd_start && armed) begin
      chk(first_tag, int'(cmd_idx), exp_first);
      armed = 0;
    end
    if (ent) ent_pend = m_pt * 2 + m_pe;
    if (lv) begin
      chk("R7", int'(trig_pend), ent_pend);
      armed = 1;
      exp_first = (mode != m_snap) ? 0 : m_ptr;
      first_tag = (mode != m_snap) ? "R9" : "R8";
    end
    prev_frozen = int'(frozen); prev_busy = int'(conv_busy); prev_en = en;
    // next state
    n_pre = (m_st == 1 || m_pre == DIV-1) ? 0 : m_pre + 1;
    n_pit = (m_st == 1) ? 0 : (qt == 1) ? ((m_pit == PER-1) ? 0 : m_pit + 1) : m_pit;
    n_busy = m_busy; n_conv = m_conv;
    if (st == 1) begin n_busy = 1; n_conv = 0; end
    else if (m_busy == 1 && qt == 1) begin
      if (m_conv == CT-1) n_busy = 0; else n_conv = m_conv + 1;
    end
    n_ptr = m_ptr;
    if (st == 1) n_ptr = (m_ptr == QL-1) ? 0 : m_ptr + 1;
    else if (lv == 1 && mode != m_snap) n_ptr = 0;
    n_pe = ((m_pe == 1 && !(st == 1 && mode == 1)) || (edg == 1 && m_st == 0 && mode == 1)) ? 1 : 0;
    n_pt = ((m_pt == 1 && !(st == 1 && mode == 2)) || (pt == 1 && mode == 2)) ? 1 : 0;
    @(posedge clk);
    if (ent == 1) begin m_snap = mode; m_st = 1; end
    else if (lv == 1) m_st = 0;
    m_pre = n_pre; m_pit = n_pit; m_busy = n_busy; m_conv = n_conv;
    m_ptr = n_ptr; m_pe = n_pe; m_pt = n_pt; m_trq = int'(ext_trig);
    if (reg_we && reg_addr == 2'd0) m_ctrl = int'(reg_wdata);
    #2;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input int val);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = DW'(val);
    tick();
    reg_we = 1'b0;
  endtask

  task automatic pulse();
    ext_trig = 1'b1; tick(); ext_trig = 1'b0; tick();
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", wd);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int s0;
    rst_n = 1'b0; frz_in = 1'b0; ext_trig = 1'b0;
    reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); @(posedge clk); #2;
    chk("R3", int'(frozen), 0);
    chk("R11", int'(cmd_start), 0);
    chk("R10", int'(reg_rdata), 0);

    // R1: enable clear, halt request ignored
    wr(2);
    frz_in = 1'b1;
    s0 = starts;
    pulse(); run(20);
    chk("R1", (starts > s0) ? 1 : 0, 1);
    chk("R1", int'(frozen), 0);

    // R2 / R7 / R8: pending trigger held through a delayed entry
    frz_in = 1'b0;
    pulse(); run(3); pulse();
    wr(3);
    frz_in = 1'b1;
    run(20);
    chk("R2", int'(frozen), 1);
    pulse();
    reg_addr = 2'd2; run(2);
    wr('hA3);
    reg_addr = 2'd0; tick();
    chk("R10", int'(reg_rdata), 'hA3);
    frz_in = 1'b0;
    run(30);

    // R9: mode rewritten while frozen
    frz_in = 1'b1; run(4);
    wr(7); run(5);
    frz_in = 1'b0; run(15);

    // R5: timer mode, freeze mid period
    wr(5); run(47);
    frz_in = 1'b1; run(9);
    frz_in = 1'b0; run(60);

    // R6: level raised during freeze, held across exit
    wr(3); run(15);
    frz_in = 1'b1; run(15);
    ext_trig = 1'b1; run(3);
    s0 = starts;
    frz_in = 1'b0; run(20);
    chk("R6", starts - s0, 0);
    chk("R6", int'(trig_pend[0]), 0);
    ext_trig = 1'b0; run(3);

    // R1: clearing the enable leaves a freeze
    frz_in = 1'b1; run(3);
    chk("R3", int'(frozen), 1);
    wr(2); run(2);
    chk("R1", int'(frozen), 0);
    pulse(); run(20);

    // R11: continuous mode wraps the index
    wr(6); frz_in = 1'b0; run(100);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule